// File: doc/BRIEF.md
# DRAM Refresh Request Generator

This block keeps dynamic or pseudo-static memory alive by periodically asking the bus arbiter for a dummy memory read. A programmable down-counter sets the spacing of these requests in clock cycles. Once the arbiter grants a request and reports that the bus cycle has finished, a 12-bit row counter advances. The next refresh then touches the next row.

The 20-bit refresh address is assembled from three parts. Address bit 0 is held at zero. Bits 12..1 carry the free-running row counter. Bits 19..13 carry a software-programmed block select, so the refreshed region can be placed on any 8 KB boundary. Software programs the block through a small write port with three targets: block base, interval and control. The current interval count is visible on an output so that it can be read back.

Top module: `refresh_gen`

## Requirements
- R1: While reset is active and right after it, `refresh_req` is 0, `refresh_addr` is 0 and `count_out` is 0.
- R2: A write with `wr_en` high loads a target chosen by `wr_sel`. The encodings are: 0 loads `wr_data[6:0]` as the block base, 1 loads `wr_data[8:0]` as the interval, and 2 loads `wr_data[0]` as the enable. A write with `wr_sel` = 3 changes nothing.
- R3: While enable is 0, `refresh_req` is 0 and `count_out` follows the interval value one cycle after that value is written.
- R4: Once enabled with interval N ≥ 1, `refresh_req` rises exactly N clock edges after the edge that set enable. An interval of 0 behaves as 1.
- R5: An asserted `refresh_req` stays high until a cycle in which `bus_grant` is high.
- R6: Expiries that occur while a request is still pending are not stored. A single grant therefore leaves no request behind unless a new expiry falls on that same edge.
- R7: On expiry the counter reloads the interval value, whether or not the earlier request has been granted. `count_out` equals the interval in the cycle in which the request is first seen.
- R8: The row counter advances by one on a `cycle_done` pulse that follows a grant. A `cycle_done` pulse with no granted cycle open is ignored.
- R9: The row counter wraps from 4095 to 0.
- R10: `refresh_addr` equals {base[6:0], row[11:0], 1'b0}.
- R11: `count_out` presents the current interval count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Write target: 0 base, 1 interval, 2 control, 3 none |
| wr_data | input | 16 | Write data |
| bus_grant | input | 1 | Arbiter grants the pending refresh cycle |
| cycle_done | input | 1 | Granted refresh cycle has completed |
| refresh_req | output | 1 | Refresh cycle request |
| refresh_addr | output | 20 | Refresh address |
| count_out | output | 9 | Current interval count |

## Verification
All configuration registers, the request flag and the row counter change at the edge that captures their cause, so each effect shows up on the first falling edge after that edge. The one exception is the request, which rises a programmed number of edges after enable. The bench drives and samples only on falling edges. It counts falling edges from the enabling write to the first sample that shows the request, and compares that count with the interval. Row and address checks are made on the sample that directly follows the `cycle_done` pulse. For the single-outstanding test, the grant is placed on an edge known not to be an expiry, so that the expected request level after the grant is unambiguous.

// File: rtl/refresh_pkg.sv
`timescale 1ns/1ps
package refresh_pkg;
    typedef enum logic [1:0] {
        SEL_BASE     = 2'd0,
        SEL_INTERVAL = 2'd1,
        SEL_CTRL     = 2'd2,
        SEL_NONE     = 2'd3
    } wr_sel_e;
endpackage

// File: rtl/refresh_cfg.sv
`timescale 1ns/1ps
module refresh_cfg #(
    parameter int DATA_W = 16,
    parameter int BASE_W = 7,
    parameter int CNT_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [BASE_W-1:0] base_o,
    output logic [CNT_W-1:0]  interval_o,
    output logic              en_o
);
    import refresh_pkg::*;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [CNT_W-1:0]  interval;
        logic              en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_sel_e'(wr_sel))
                SEL_BASE:     cfg_d.base     = wr_data[BASE_W-1:0];
                SEL_INTERVAL: cfg_d.interval = wr_data[CNT_W-1:0];
                SEL_CTRL:     cfg_d.en       = wr_data[0];
                default:      cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign base_o     = cfg_q.base;
    assign interval_o = cfg_q.interval;
    assign en_o       = cfg_q.en;
endmodule

// File: rtl/refresh_interval.sv
`timescale 1ns/1ps
module refresh_interval #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] interval_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);
    logic [CNT_W-1:0] count_d, count_q;
    logic             at_end;

    assign at_end = (count_q <= CNT_W'(1));

    always_comb begin
        if (!en_i || at_end) count_d = interval_i;
        else                 count_d = count_q - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count_o  = count_q;
    assign expire_o = en_i && at_end;
endmodule

// File: rtl/refresh_row.sv
`timescale 1ns/1ps
module refresh_row #(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    output logic [ROW_W-1:0] row_o
);
    logic [ROW_W-1:0] row_d, row_q;

    always_comb begin
        row_d = row_q;
        if (step_i) row_d = row_q + ROW_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    assign row_o = row_q;
endmodule

// File: rtl/refresh_gen.sv
`timescale 1ns/1ps
module refresh_gen #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 20,
    parameter int ROW_W  = 12,
    parameter int CNT_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bus_grant,
    input  logic              cycle_done,
    output logic              refresh_req,
    output logic [ADDR_W-1:0] refresh_addr,
    output logic [CNT_W-1:0]  count_out
);
    localparam int BASE_W = ADDR_W - ROW_W - 1;

    typedef struct packed {
        logic req;
        logic busy;
    } hs_t;

    hs_t hs_d, hs_q;

    logic [BASE_W-1:0] base_q;
    logic [CNT_W-1:0]  interval_q;
    logic              en_q;
    logic              expire;
    logic              row_step;
    logic [ROW_W-1:0]  row_q;

    refresh_cfg #(.DATA_W(DATA_W), .BASE_W(BASE_W), .CNT_W(CNT_W)) i_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .base_o(base_q), .interval_o(interval_q), .en_o(en_q)
    );

    refresh_interval #(.CNT_W(CNT_W)) i_interval (
        .clk(clk), .rst_n(rst_n), .en_i(en_q), .interval_i(interval_q),
        .count_o(count_out), .expire_o(expire)
    );

    refresh_row #(.ROW_W(ROW_W)) i_row (
        .clk(clk), .rst_n(rst_n), .step_i(row_step), .row_o(row_q)
    );

    always_comb begin
        hs_d     = hs_q;
        row_step = cycle_done && hs_q.busy;
        if (!en_q) begin
            hs_d.req = 1'b0;
        end else begin
            if (bus_grant && hs_q.req) begin
                hs_d.req  = 1'b0;
                hs_d.busy = 1'b1;
            end
            if (expire) hs_d.req = 1'b1;
        end
        if (row_step) hs_d.busy = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hs_q <= '0;
        else        hs_q <= hs_d;
    end

    assign refresh_req  = hs_q.req;
    assign refresh_addr = {base_q, row_q, 1'b0};
endmodule

// File: rtl/refresh_gen_chk.sv
`timescale 1ns/1ps
module refresh_gen_chk #(
    parameter int ADDR_W = 20,
    parameter int ROW_W  = 12,
    parameter int CNT_W  = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              en_q,
    input logic [CNT_W-1:0]  interval_q,
    input logic              busy_q,
    input logic              bus_grant,
    input logic              cycle_done,
    input logic              refresh_req,
    input logic [ADDR_W-1:0] refresh_addr,
    input logic [CNT_W-1:0]  count_out
);
    localparam int BASE_W = ADDR_W - ROW_W - 1;

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && refresh_req && !bus_grant) |=> refresh_req);

    assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (!refresh_req && count_out == $past(interval_q)));

    assert_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(refresh_addr[ADDR_W-1 -: BASE_W]));

    assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cycle_done) |=>
            refresh_addr[ROW_W:1] == $past(refresh_addr[ROW_W:1]) + ROW_W'(1));

    assert_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_q && cycle_done) |=> $stable(refresh_addr[ROW_W:1]));
endmodule

bind refresh_gen refresh_gen_chk #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .en_q(en_q), .interval_q(interval_q),
    .busy_q(hs_q.busy), .bus_grant(bus_grant), .cycle_done(cycle_done),
    .refresh_req(refresh_req), .refresh_addr(refresh_addr), .count_out(count_out)
);

// File: tb/test_refresh_gen.sv
`timescale 1ns/1ps
module test_refresh_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        bus_grant = 1'b0;
    logic        cycle_done = 1'b0;
    logic        refresh_req;
    logic [19:0] refresh_addr;
    logic [8:0]  count_out;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [6:0]  cur_base = '0;
    logic [11:0] exp_row = '0;

    // vector = {block base[6:0], interval[8:0]}
    localparam logic [15:0] VEC [5] = '{
        {7'h00, 9'd3}, {7'h7F, 9'd1}, {7'h2A, 9'd0}, {7'h15, 9'd7}, {7'h40, 9'd12}
    };

    always #2.5 clk = ~clk;

    refresh_gen i_refresh_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .bus_grant(bus_grant), .cycle_done(cycle_done), .refresh_req(refresh_req),
        .refresh_addr(refresh_addr), .count_out(count_out)
    );

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic write(input logic [1:0] sel, input logic [15:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        step();
        wr_en = 1'b0;
    endtask

    task automatic wait_req(output int cnt);
        cnt = 0;
        while (!refresh_req && cnt < 5000) begin
            step();
            cnt++;
        end
    endtask

    task automatic grant_and_done();
        bus_grant = 1'b1; step(); bus_grant = 1'b0;
        cycle_done = 1'b1; step(); cycle_done = 1'b0;
        exp_row = exp_row + 12'd1;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int cnt;
        step(); step();
        // R1: reset state
        check(refresh_req == 1'b0, "R1 req in reset", 32'(refresh_req), 0);
        check(refresh_addr == 20'd0, "R1 addr in reset", 32'(refresh_addr), 0);
        rst_n = 1'b1;
        step();
        check(count_out == 9'd0, "R1 count after reset", 32'(count_out), 0);

        foreach (VEC[v]) begin
            logic [6:0] b;
            logic [8:0] n;
            int lat;
            b = VEC[v][15:9];
            n = VEC[v][8:0];
            lat = (n == 0) ? 1 : int'(n);
            write(2'd2, 16'd0);
            write(2'd0, {9'd0, b});
            cur_base = b;
            write(2'd1, {7'd0, n});
            step();
            check(count_out == n, "R3 R11 count held at interval", 32'(count_out), 32'(n));
            check(refresh_req == 1'b0, "R3 no request while disabled", 32'(refresh_req), 0);
            write(2'd2, 16'd1);
            wait_req(cnt);
            check(cnt == lat, "R4 request latency", 32'(cnt), 32'(lat));
            check(count_out == n, "R7 reload at expiry", 32'(count_out), 32'(n));
            check(refresh_addr == {cur_base, exp_row, 1'b0}, "R10 address format",
                  32'(refresh_addr), 32'({cur_base, exp_row, 1'b0}));
            step(); step();
            check(refresh_req == 1'b1, "R5 request held without grant", 32'(refresh_req), 1);
            grant_and_done();
            check(refresh_addr == {cur_base, exp_row, 1'b0}, "R8 row advance after cycle",
                  32'(refresh_addr), 32'({cur_base, exp_row, 1'b0}));
        end

        // R2: select 3 ignored
        write(2'd2, 16'd0);
        step();
        write(2'd3, 16'hFFFF);
        step();
        check(refresh_addr == {cur_base, exp_row, 1'b0}, "R2 sel3 leaves address",
              32'(refresh_addr), 32'({cur_base, exp_row, 1'b0}));
        check(count_out == 9'd12, "R2 sel3 leaves interval", 32'(count_out), 12);

        // R6: only one outstanding request
        write(2'd1, 16'd5);
        write(2'd2, 16'd1);
        wait_req(cnt);
        for (int i = 0; i < 10; i++) step();
        check(refresh_req == 1'b1, "R5 still pending after expiries", 32'(refresh_req), 1);
        check(count_out == 9'd5, "R7 reload while pending", 32'(count_out), 5);
        bus_grant = 1'b1; step(); bus_grant = 1'b0;
        check(refresh_req == 1'b0, "R6 single grant clears all", 32'(refresh_req), 0);
        check(count_out == 9'd4, "R6 count continues", 32'(count_out), 4);
        cycle_done = 1'b1; step(); cycle_done = 1'b0;
        exp_row = exp_row + 12'd1;
        check(refresh_addr[12:1] == exp_row, "R8 row after pending cycle",
              32'(refresh_addr[12:1]), 32'(exp_row));

        // R8: stray cycle_done ignored
        cycle_done = 1'b1; step(); cycle_done = 1'b0;
        check(refresh_addr[12:1] == exp_row, "R8 stray done ignored",
              32'(refresh_addr[12:1]), 32'(exp_row));

        // R9: wrap of row counter
        write(2'd1, 16'd1);
        begin
            logic [11:0] start_row;
            bit seen_zero;
            start_row = exp_row;
            seen_zero = 1'b0;
            for (int i = 0; i < 4096; i++) begin
                wait_req(cnt);
                grant_and_done();
                if (exp_row == 12'd0) begin
                    seen_zero = 1'b1;
                    check(refresh_addr[12:1] == 12'd0, "R9 wrap to zero",
                          32'(refresh_addr[12:1]), 0);
                end
            end
            check(seen_zero, "R9 wrap reached", 32'(seen_zero), 1);
            check(refresh_addr[12:1] == start_row, "R9 full cycle returns",
                  32'(refresh_addr[12:1]), 32'(start_row));
        end

        // R1: reset during operation
        rst_n = 1'b0;
        step();
        check(refresh_req == 1'b0, "R1 req after mid reset", 32'(refresh_req), 0);
        check(refresh_addr == 20'd0, "R1 addr after mid reset", 32'(refresh_addr), 0);
        check(count_out == 9'd0, "R1 count after mid reset", 32'(count_out), 0);
        rst_n = 1'b1;
        step();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule